// File: doc/BRIEF.md
# Cyclic wake-up interval timer

This block paces periodic wake-ups while the chip sits in a low-power state. Each wake-up either starts a cyclic sense of the inputs or forces the chip awake. An external prescaler supplies a one-cycle strobe every millisecond. The block counts those strobes and raises a one-cycle wake pulse each time a full interval has elapsed. It then carries straight on with the next interval.

Two configuration inputs set the interval. A 3-bit interval code gives the base length in steps of 20 ms. A separate stretch bit multiplies that length by eight. The two settings live in different configuration registers, so they can change on different cycles. An interval code of zero turns the whole function off. A mode-active input gates counting: the count only advances while the low-power mode is active.

Top module: `cyc_wake_timer`

## Requirements
- R1: After reset the wake output is low, and the first interval counts from zero.
- R2: An interval code of 0 produces no wake pulse at all, whether the stretch bit is 0 or 1.
- R3: With the stretch bit at 0, interval codes 1 to 7 give a period of 20 × code ticks (20 to 140 ms).
- R4: With the stretch bit at 1, interval codes 1 to 7 give a period of 160 × code ticks (160 to 1120 ms).
- R5: Each wake pulse is high for exactly one clock cycle. Counting then continues, so the next pulse follows after one more full period.
- R6: Any change of the interval code or the stretch bit restarts the count from zero. If the change falls in the same cycle as the tick that would end an interval, no pulse is produced.
- R7: While mode-active is low the count holds at zero and no pulse appears. A rising edge on mode-active starts a fresh interval.
- R8: Only clock cycles with the tick input high advance the count. The pulse appears in the clock cycle right after the tick that completes the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; it is released in step with the clock |
| tick_i | input | 1 | One-cycle strobe, once per millisecond |
| active_i | input | 1 | High while the low-power mode is in force |
| code_i | input | 3 | Interval code; 0 turns the function off |
| ext_i | input | 1 | Stretch bit; 1 makes the period eight times longer |
| wake_o | output | 1 | One-cycle wake pulse at the end of each interval |

## Verification
The two functions that can meet in one cycle are the end-of-interval tick and a restart. The restart comes either from a configuration change or from the rising edge of mode-active. The bench provokes the clash by changing the interval code, or raising mode-active, in exactly the cycle whose tick would complete the interval. The scoreboard then expects no pulse from that tick. It expects the next pulse a full new period later, counted from the change. Any pulse that arrives on the old schedule, or a missing pulse on the new one, is reported against R6 or R7.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

  // default configuration of the wake timer
  parameter int unsigned CODE_W_DEF     = 3;
  parameter int unsigned BASE_TICKS_DEF = 20;
  parameter int unsigned EXT_MULT_DEF   = 8;

  // counter width able to hold the longest period
  function automatic int unsigned cnt_width(input int unsigned code_w,
                                            input int unsigned base_ticks,
                                            input int unsigned ext_mult);
    int unsigned longest;
    longest = base_ticks * ((32'd1 << code_w) - 1) * ext_mult;
    return $clog2(longest + 1);
  endfunction

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/cwt_rst_sync.sv
module cwt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[STAGES-1];

endmodule

// File: rtl/cwt_period_sel.sv
module cwt_period_sel #(
  parameter int unsigned CODE_W     = 3,
  parameter int unsigned BASE_TICKS = 20,
  parameter int unsigned EXT_MULT   = 8,
  parameter int unsigned CNT_W      = 11
) (
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_i,
  output logic              enable_o,
  output logic [CNT_W-1:0]  limit_o
);

  localparam logic [CNT_W-1:0] BASE_W = CNT_W'(BASE_TICKS);

  logic [CNT_W-1:0] base_len;
  logic [CNT_W-1:0] long_len;

  always_comb begin
    base_len = CNT_W'(code_i) * BASE_W;
  end

  // the stretch is a plain shift when the factor is a power of two
  generate
    if (cwt_pkg::is_pow2(EXT_MULT)) begin : g_shift
      localparam int unsigned SHIFT = $clog2(EXT_MULT);
      always_comb begin
        long_len = base_len << SHIFT;
      end
    end else begin : g_mult
      localparam logic [CNT_W-1:0] MULT_W = CNT_W'(EXT_MULT);
      always_comb begin
        long_len = base_len * MULT_W;
      end
    end
  endgenerate

  always_comb begin
    enable_o = (code_i != '0);
    limit_o  = ext_i ? long_len : base_len;
  end

endmodule

// File: rtl/cwt_restart_det.sv
module cwt_restart_det #(
  parameter int unsigned CODE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_i,
  input  logic              active_i,
  output logic              restart_o
);

  logic [CODE_W-1:0] code_q, code_d;
  logic              ext_q, ext_d;
  logic              act_q, act_d;
  logic              code_chg, ext_chg, act_rise;

  always_comb begin
    code_d   = code_i;
    ext_d    = ext_i;
    act_d    = active_i;
    code_chg = (code_i != code_q);
    ext_chg  = (ext_i != ext_q);
    act_rise = active_i & ~act_q;
    restart_o = code_chg | ext_chg | act_rise;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      ext_q  <= 1'b0;
      act_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      ext_q  <= ext_d;
      act_q  <= act_d;
    end
  end

endmodule

// File: rtl/cwt_interval_cnt.sv
module cwt_interval_cnt #(
  parameter int unsigned CNT_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             run_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             wake_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             at_end;
  logic             wake_q, wake_d;

  always_comb begin
    at_end = ({1'b0, cnt_q} + 1'b1) >= {1'b0, limit_i};
    cnt_en = restart_i | ~run_i | tick_i;
    cnt_d  = cnt_q;
    wake_d = 1'b0;
    if (restart_i || !run_i) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (at_end) begin
        cnt_d  = '0;
        wake_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q <= 1'b0;
    end else begin
      wake_q <= wake_d;
    end
  end

  assign wake_o = wake_q;

endmodule

// File: rtl/cyc_wake_timer.sv
module cyc_wake_timer #(
  parameter int unsigned CODE_W     = cwt_pkg::CODE_W_DEF,
  parameter int unsigned BASE_TICKS = cwt_pkg::BASE_TICKS_DEF,
  parameter int unsigned EXT_MULT   = cwt_pkg::EXT_MULT_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              active_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              ext_i,
  output logic              wake_o
);

  localparam int unsigned CNT_W = cwt_pkg::cnt_width(CODE_W, BASE_TICKS, EXT_MULT);

  logic             rst_sync_n;
  logic             cfg_enable;
  logic [CNT_W-1:0] limit;
  logic             restart;
  logic             run;

  cwt_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  cwt_period_sel #(
    .CODE_W     (CODE_W),
    .BASE_TICKS (BASE_TICKS),
    .EXT_MULT   (EXT_MULT),
    .CNT_W      (CNT_W)
  ) u_period_sel (
    .code_i   (code_i),
    .ext_i    (ext_i),
    .enable_o (cfg_enable),
    .limit_o  (limit)
  );

  cwt_restart_det #(.CODE_W(CODE_W)) u_restart_det (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .code_i    (code_i),
    .ext_i     (ext_i),
    .active_i  (active_i),
    .restart_o (restart)
  );

  always_comb begin
    run = active_i & cfg_enable;
  end

  cwt_interval_cnt #(.CNT_W(CNT_W)) u_interval_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_sync_n),
    .tick_i    (tick_i),
    .run_i     (run),
    .restart_i (restart),
    .limit_i   (limit),
    .wake_o    (wake_o)
  );

endmodule

// File: rtl/cyc_wake_timer_chk.sv
module cyc_wake_timer_chk #(
  parameter int unsigned CODE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              active_i,
  input logic [CODE_W-1:0] code_i,
  input logic              ext_i,
  input logic              wake_o
);

  // R5
  wake_single_cycle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |=> !wake_o);

  // R2
  code_zero_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i == '0) |=> !wake_o);

  // R7
  inactive_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !wake_o);

  // R8
  wake_after_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(tick_i));

  // R6
  code_change_no_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_i != $past(code_i)) |=> !wake_o);

  // R6
  ext_change_no_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_i != $past(ext_i)) |=> !wake_o);

endmodule

bind cyc_wake_timer cyc_wake_timer_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .active_i (active_i),
  .code_i   (code_i),
  .ext_i    (ext_i),
  .wake_o   (wake_o)
);

// File: tb/cyc_wake_timer_bench.sv
module cyc_wake_timer_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       active = 1'b0;
  logic       ext = 1'b0;
  logic [2:0] code = 3'd0;
  logic       wake;

  always #2 clk = ~clk;

  cyc_wake_timer u_cyc_wake_timer (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .active_i (active),
    .code_i   (code),
    .ext_i    (ext),
    .wake_o   (wake)
  );

  typedef struct {
    int    stamp;
    string req;
  } exp_t;

  exp_t  exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  int    phase_seen = 0;
  int    phase_pushed = 0;
  bit    mon_on = 1'b0;
  string cur_req = "R1";

  int         m_cnt = 0;
  logic [2:0] p_code = 3'd0;
  logic       p_ext = 1'b0;
  logic       p_act = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: pops one expected pulse per observed pulse
  always @(negedge clk) begin
    if (mon_on && wake) begin
      exp_t e;
      checks++;
      phase_seen++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL %s unexpected wake pulse: actual cycle=%0d expected none", cur_req, cyc);
      end else begin
        e = exp_q.pop_front();
        if (e.stamp != cyc) begin
          fails++;
          $display("FAIL %s wake pulse cycle: actual=%0d expected=%0d", e.req, cyc, e.stamp);
        end
      end
    end
  end

  // driver: one clock step with the current config, model predicts pulses
  task automatic step(input bit tk);
    int lim;
    tick = tk;
    if (code != p_code || ext != p_ext || (active && !p_act)) begin
      m_cnt = 0;
    end else if (active && code != 3'd0 && tk) begin
      lim = 20 * int'(code) * (ext ? 8 : 1);
      if (m_cnt == lim - 1) begin
        exp_t e;
        e.stamp = cyc + 1;
        e.req   = cur_req;
        exp_q.push_back(e);
        phase_pushed++;
        m_cnt = 0;
      end else begin
        m_cnt++;
      end
    end
    p_code = code;
    p_ext  = ext;
    p_act  = active;
    @(negedge clk);
  endtask

  task automatic run_ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1);
      for (int g = 0; g < gap; g++) step(1'b0);
    end
  endtask

  task automatic begin_phase(input string req);
    cur_req      = req;
    phase_seen   = 0;
    phase_pushed = 0;
  endtask

  task automatic end_phase(input int want);
    step(1'b0);
    step(1'b0);
    checks++;
    if (phase_seen != want || phase_pushed != want) begin
      fails++;
      $display("FAIL %s pulse count: actual=%0d expected=%0d", cur_req, phase_seen, want);
    end
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: output low in reset
    checks++;
    if (wake !== 1'b0) begin
      fails++;
      $display("FAIL R1 wake in reset: actual=%b expected=0", wake);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R1: first interval after reset counts from zero
    begin_phase("R1");
    active = 1'b1; code = 3'd1; step(1'b0);
    run_ticks(20, 0);
    end_phase(1);

    // R2: code 0 with either stretch setting stays silent
    begin_phase("R2");
    code = 3'd0; ext = 1'b0; step(1'b0);
    run_ticks(200, 0);
    end_phase(0);
    begin_phase("R2");
    ext = 1'b1; step(1'b0);
    run_ticks(1200, 0);
    end_phase(0);

    // R3 and R5: base periods, two back-to-back intervals each
    for (int c = 1; c < 8; c++) begin
      begin_phase("R3");
      code = 3'(c); ext = 1'b0; step(1'b0);
      run_ticks(40 * c, 0);
      end_phase(2);
    end

    // R4 and R5: stretched periods
    for (int c = 1; c < 8; c++) begin
      begin_phase("R4");
      code = 3'(c); ext = 1'b1; step(1'b0);
      run_ticks(320 * c, 0);
      end_phase(2);
    end

    // R8: sparse ticks, only tick cycles count
    begin_phase("R8");
    code = 3'd1; ext = 1'b0; step(1'b0);
    run_ticks(40, 3);
    end_phase(2);

    // R6: code change mid interval restarts the count
    begin_phase("R6");
    code = 3'd2; step(1'b0);
    run_ticks(30, 0);
    code = 3'd1; step(1'b0);
    run_ticks(20, 0);
    end_phase(1);

    // R6: code change on the completing tick suppresses that pulse
    begin_phase("R6");
    run_ticks(19, 0);
    code = 3'd2; step(1'b1);
    run_ticks(40, 0);
    end_phase(1);

    // R6: stretch change restarts too
    begin_phase("R6");
    code = 3'd1; ext = 1'b0; step(1'b0);
    run_ticks(10, 0);
    ext = 1'b1; step(1'b0);
    run_ticks(160, 0);
    end_phase(1);

    // R7: inactive holds zero, rise restarts
    begin_phase("R7");
    ext = 1'b0; step(1'b0);
    run_ticks(15, 0);
    active = 1'b0; step(1'b0);
    run_ticks(50, 0);
    active = 1'b1; step(1'b0);
    run_ticks(20, 0);
    end_phase(1);

    // R7: mode-active rise on what would be a completing tick
    begin_phase("R7");
    run_ticks(19, 0);
    active = 1'b0; step(1'b0);
    active = 1'b1; step(1'b1);
    run_ticks(19, 0);
    end_phase(0);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R5 pending pulses: actual=%0d expected=0", exp_q.size());
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule